// File: doc/BRIEF.md
# Snooping Write-Invalidate Line-State Controller

This block keeps coherence state for a small direct-mapped set of cache lines inside one processor's cache on a shared, atomic bus. Each line is Invalid, Shared or Modified. Processor reads and writes that hit complete in the same cycle. Misses become bus transactions: a read, a read-for-ownership, or a data-less upgrade when the line is already Shared. The request is held until the bus arbiter grants it.

The same block watches every transaction that other caches put on the bus. A snooped read that finds a Modified line makes this cache the data source: it raises an ownership response that keeps memory from answering, presents the line's data, asks for a memory writeback and drops to Shared. A snooped ownership request or upgrade removes any local copy. A Modified owner hands over its data in the same cycle.

Each line stands for one fixed block address, so the line index is the whole address and no tags or evictions exist. The cache's own bus traffic may be looped back on the snoop inputs. It is recognised by its requester ID and ignored there.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid: no snoop gets an ownership response, and the first processor access to any line goes to the bus.
- R2: A read of an Invalid line raises `bus_req`. In the grant cycle it drives command 2'b01 (read) with the line index and this cache's ID. It completes when `bus_rsp_valid` arrives, returns `bus_rsp_data`, and leaves the line Shared.
- R3: A read of a Shared or Modified line completes in the same cycle with the stored data and no bus request.
- R4: A write to a Shared line drives command 2'b11 (upgrade) in its grant cycle and completes in that same cycle without a data response. The line becomes Modified and holds the written data.
- R5: A write to an Invalid line drives command 2'b10 (read-for-ownership) in its grant cycle. It completes on the response, and the line becomes Modified with the written data.
- R6: A write to a Modified line completes in the same cycle with no bus request and updates the stored data.
- R7: A snooped read from another cache on a Shared or Invalid line changes nothing and raises no ownership response.
- R8: A snooped read from another cache on a Modified line raises `snp_owned` and `snp_wb` in the same cycle and presents the line data on `snp_data`. The line becomes Shared.
- R9: A snooped read-for-ownership from another cache on a Modified line raises `snp_owned` with the data but not `snp_wb`. The line becomes Invalid.
- R10: A snooped read-for-ownership or upgrade from another cache on a Shared line makes it Invalid without an ownership response.
- R11: Snooped commands that carry this cache's own ID have no effect on state or responses.
- R12: While a miss is outstanding, `cpu_ready` stays low. `bus_req` stays high until granted, and `bus_cmd` is 2'b00 in every cycle without a grant.
- R13: A snoop from another cache on the same line as a processor access defers that access by a cycle. A pending write whose Shared line is invalidated before the grant issues read-for-ownership instead of upgrade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | IDX_W | Line index / block address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 00 none, 01 read, 10 read-for-ownership, 11 upgrade |
| bus_addr | output | IDX_W | Address of the issued transaction |
| bus_id | output | ID_W | Requester ID of the issued transaction |
| bus_rsp_valid | input | 1 | Data response for this cache's read or read-for-ownership |
| bus_rsp_data | input | DATA_W | Response data |
| snp_cmd | input | 2 | Snooped bus command, same encoding as `bus_cmd` |
| snp_addr | input | IDX_W | Snooped address |
| snp_id | input | ID_W | Snooped requester ID |
| snp_owned | output | 1 | This cache owns the line and supplies its data |
| snp_wb | output | 1 | Memory must take the supplied block |
| snp_data | output | DATA_W | Supplied line data |

## Verification
On every cycle the assertions check the bus-side rules. A command appears only under request and grant, and a request is held until it is granted. Ownership and writeback responses come only from foreign reads or ownership requests, and writeback only with ownership on a read. An upgrade completes in its grant cycle, while a data miss never does. The state transitions themselves are shown only by the bench. It sweeps every pair of processor and snoop operations on every line from Invalid and then probes the result with a read. Directed scenarios cover a snoop racing a processor hit and an upgrade that is overtaken by an invalidation.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_MOD = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_UPGR = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    RQ_IDLE = 2'b00,
    RQ_ARB  = 2'b01,
    RQ_WAIT = 2'b10
  } req_st_e;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          snp_st,
  input  logic              cpu_en,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  line_st_e          cpu_st,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  output line_st_e          st_all   [NUM_LINES],
  output logic [DATA_W-1:0] data_all [NUM_LINES]
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e          st_q, st_d;
    logic              st_en, dat_en;
    logic [DATA_W-1:0] dat_q;

    // snoop updates win over processor updates on the same line
    always_comb begin
      st_en = 1'b0;
      st_d  = st_q;
      if (snp_en && snp_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = snp_st;
      end else if (cpu_en && cpu_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = cpu_st;
      end
    end

    assign dat_en = cpu_wr_en && (cpu_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= LN_INV;
      else if (st_en) st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (dat_en) dat_q <= cpu_wr_data;
    end

    assign st_all[g]   = st_q;
    assign data_all[g] = dat_q;
  end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 0,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [1:0]        snp_cmd,
  input  logic [IDX_W-1:0]  snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  input  line_st_e          st_all   [NUM_LINES],
  input  logic [DATA_W-1:0] data_all [NUM_LINES],
  output logic              foreign,
  output logic              owned,
  output logic              wb,
  output logic [DATA_W-1:0] data,
  output logic              upd_en,
  output line_st_e          upd_st
);
  line_st_e cur;

  assign cur     = st_all[snp_addr];
  assign foreign = (snp_cmd != CMD_NONE) && (snp_id != ID_W'(MY_ID));

  always_comb begin
    owned  = 1'b0;
    wb     = 1'b0;
    upd_en = 1'b0;
    upd_st = cur;
    if (foreign) begin
      case (snp_cmd)
        CMD_RD: begin
          if (cur == LN_MOD) begin
            owned  = 1'b1;
            wb     = 1'b1;
            upd_en = 1'b1;
            upd_st = LN_SHR;
          end
        end
        CMD_RDX: begin
          if (cur != LN_INV) begin
            owned  = (cur == LN_MOD);
            upd_en = 1'b1;
            upd_st = LN_INV;
          end
        end
        CMD_UPGR: begin
          if (cur != LN_INV) begin
            upd_en = 1'b1;
            upd_st = LN_INV;
          end
        end
        default: ;
      endcase
    end
  end

  assign data = owned ? data_all[snp_addr] : '0;
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  line_st_e          cur_st,
  input  logic [DATA_W-1:0] cur_data,
  input  line_st_e          pend_st,
  input  logic              snp_conflict,
  input  logic              bus_gnt,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output bus_cmd_e          bus_cmd,
  output logic [IDX_W-1:0]  bus_addr,
  output logic [ID_W-1:0]   bus_id,
  output logic [IDX_W-1:0]  pend_idx,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output line_st_e          upd_st,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data
);
  req_st_e           fsm_q, fsm_d;
  logic              latch_en;
  logic              req_wr_q;
  logic [IDX_W-1:0]  req_idx_q;
  logic [DATA_W-1:0] req_wdata_q;
  bus_cmd_e          want_cmd;

  // the command is chosen at grant time from the live line state
  always_comb begin
    if (!req_wr_q)              want_cmd = CMD_RD;
    else if (pend_st == LN_SHR) want_cmd = CMD_UPGR;
    else                        want_cmd = CMD_RDX;
  end

  always_comb begin
    fsm_d     = fsm_q;
    latch_en  = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = '0;
    bus_req   = 1'b0;
    bus_cmd   = CMD_NONE;
    upd_en    = 1'b0;
    upd_idx   = req_idx_q;
    upd_st    = LN_MOD;
    wr_en     = 1'b0;
    wr_data   = req_wdata_q;
    case (fsm_q)
      RQ_IDLE: begin
        if (cpu_valid && !snp_conflict) begin
          if (!cpu_write && cur_st != LN_INV) begin
            cpu_ready = 1'b1;
            cpu_rdata = cur_data;
          end else if (cpu_write && cur_st == LN_MOD) begin
            cpu_ready = 1'b1;
            wr_en     = 1'b1;
            upd_idx   = cpu_addr;
            wr_data   = cpu_wdata;
          end else begin
            latch_en = 1'b1;
            fsm_d    = RQ_ARB;
          end
        end
      end
      RQ_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) begin
          bus_cmd = want_cmd;
          if (want_cmd == CMD_UPGR) begin
            cpu_ready = 1'b1;
            upd_en    = 1'b1;
            upd_st    = LN_MOD;
            wr_en     = 1'b1;
            fsm_d     = RQ_IDLE;
          end else begin
            fsm_d = RQ_WAIT;
          end
        end
      end
      RQ_WAIT: begin
        if (bus_rsp_valid) begin
          cpu_ready = 1'b1;
          upd_en    = 1'b1;
          wr_en     = 1'b1;
          fsm_d     = RQ_IDLE;
          if (req_wr_q) begin
            upd_st = LN_MOD;
          end else begin
            upd_st    = LN_SHR;
            wr_data   = bus_rsp_data;
            cpu_rdata = bus_rsp_data;
          end
        end
      end
      default: fsm_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= RQ_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_ff @(posedge clk) begin
    if (latch_en) begin
      req_wr_q    <= cpu_write;
      req_idx_q   <= cpu_addr;
      req_wdata_q <= cpu_wdata;
    end
  end

  assign bus_addr = req_idx_q;
  assign bus_id   = ID_W'(MY_ID);
  assign pend_idx = req_idx_q;
endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DATA_W    = 8,
  parameter int ID_W      = 2,
  parameter int MY_ID     = 0,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [IDX_W-1:0]  bus_addr,
  output logic [ID_W-1:0]   bus_id,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic [1:0]        snp_cmd,
  input  logic [IDX_W-1:0]  snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              snp_owned,
  output logic              snp_wb,
  output logic [DATA_W-1:0] snp_data
);
  logic              rst_n_s;
  line_st_e          st_all   [NUM_LINES];
  logic [DATA_W-1:0] data_all [NUM_LINES];
  logic              snp_foreign, snp_upd_en;
  line_st_e          snp_upd_st;
  logic              cpu_upd_en, cpu_wr_en;
  logic [IDX_W-1:0]  cpu_upd_idx, pend_idx;
  line_st_e          cpu_upd_st;
  logic [DATA_W-1:0] cpu_wr_data;
  bus_cmd_e          cmd_int;

  msi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  msi_line_store #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .snp_en      (snp_upd_en),
    .snp_idx     (snp_addr),
    .snp_st      (snp_upd_st),
    .cpu_en      (cpu_upd_en),
    .cpu_idx     (cpu_upd_idx),
    .cpu_st      (cpu_upd_st),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_data (cpu_wr_data),
    .st_all      (st_all),
    .data_all    (data_all)
  );

  msi_snoop_unit #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_snoop (
    .snp_cmd  (snp_cmd),
    .snp_addr (snp_addr),
    .snp_id   (snp_id),
    .st_all   (st_all),
    .data_all (data_all),
    .foreign  (snp_foreign),
    .owned    (snp_owned),
    .wb       (snp_wb),
    .data     (snp_data),
    .upd_en   (snp_upd_en),
    .upd_st   (snp_upd_st)
  );

  msi_req_fsm #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
  ) u_req (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cur_st        (st_all[cpu_addr]),
    .cur_data      (data_all[cpu_addr]),
    .pend_st       (st_all[pend_idx]),
    .snp_conflict  (snp_foreign && (snp_addr == cpu_addr)),
    .bus_gnt       (bus_gnt),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_data  (bus_rsp_data),
    .cpu_ready     (cpu_ready),
    .cpu_rdata     (cpu_rdata),
    .bus_req       (bus_req),
    .bus_cmd       (cmd_int),
    .bus_addr      (bus_addr),
    .bus_id        (bus_id),
    .pend_idx      (pend_idx),
    .upd_en        (cpu_upd_en),
    .upd_idx       (cpu_upd_idx),
    .upd_st        (cpu_upd_st),
    .wr_en         (cpu_wr_en),
    .wr_data       (cpu_wr_data)
  );

  assign bus_cmd = cmd_int;
endmodule

// File: rtl/msi_coherence_chk.sv
module msi_coherence_chk #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_ready,
  input logic            bus_req,
  input logic            bus_gnt,
  input logic [1:0]      bus_cmd,
  input logic [1:0]      snp_cmd,
  input logic [ID_W-1:0] snp_id,
  input logic            snp_owned,
  input logic            snp_wb
);
  a_r12_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00) |-> (bus_req && bus_gnt));

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  a_r8_owned_from_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    snp_owned |-> ((snp_cmd == 2'b01 || snp_cmd == 2'b10) && snp_id != ID_W'(MY_ID)));

  a_r8_wb_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> (snp_owned && snp_cmd == 2'b01));

  a_r11_own_id_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_id == ID_W'(MY_ID)) |-> (!snp_owned && !snp_wb));

  a_r4_upgrade_done_at_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'b11) |-> cpu_ready);

  a_r5_data_miss_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'b01 || bus_cmd == 2'b10) |-> !cpu_ready);
endmodule

bind msi_coherence_ctrl msi_coherence_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cmd   (bus_cmd),
  .snp_cmd   (snp_cmd),
  .snp_id    (snp_id),
  .snp_owned (snp_owned),
  .snp_wb    (snp_wb)
);

// File: tb/test_msi_coherence_ctrl.sv
`timescale 1ns/1ps
module test_msi_coherence_ctrl;
  localparam int NL = 4, DW = 8, IW = 2, ME = 1;
  localparam int ST_I = 0, ST_S = 1, ST_M = 2;

  logic clk, rst_n;
  logic cpu_valid, cpu_write, cpu_ready;
  logic [1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic bus_req, bus_gnt, bus_rsp_valid;
  logic [1:0] bus_cmd, bus_addr;
  logic [IW-1:0] bus_id;
  logic [DW-1:0] bus_rsp_data;
  logic [1:0] snp_cmd, snp_addr;
  logic [IW-1:0] snp_id;
  logic snp_owned, snp_wb;
  logic [DW-1:0] snp_data;

  int checks = 0, errors = 0, seq = 0;
  bit done = 0;
  int mst [NL];
  logic [DW-1:0] mdat [NL];

  msi_coherence_ctrl #(.NUM_LINES(NL), .DATA_W(DW), .ID_W(IW), .MY_ID(ME)) i_msi_coherence_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_id(bus_id), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_id(snp_id),
    .snp_owned(snp_owned), .snp_wb(snp_wb), .snp_data(snp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  // processor access; expectation derived from the bench model
  task automatic do_cpu(input bit wr, input int idx);
    logic [DW-1:0] wd, rsp;
    int kind, gd;
    string tg;
    seq++;
    wd  = DW'(8'h30 + seq);
    rsp = DW'(8'hA0 + seq);
    gd  = (idx + seq) % 3;
    if (!wr) kind = (mst[idx] != ST_I) ? 0 : 2;
    else     kind = (mst[idx] == ST_M) ? 0 : ((mst[idx] == ST_S) ? 3 : 1);
    tg = !wr ? (kind == 0 ? "R3" : "R2") : (kind == 0 ? "R6" : (kind == 3 ? "R4" : "R5"));
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = 2'(idx); cpu_wdata = wd;
    #1;
    if (kind == 0) begin
      chk(cpu_ready == 1 && bus_req == 0, tg, {cpu_ready, bus_req}, 2'b10);
      if (!wr) chk(cpu_rdata == mdat[idx], tg, cpu_rdata, mdat[idx]);
      @(negedge clk); cpu_valid = 0;
      if (wr) mdat[idx] = wd;
      return;
    end
    chk(cpu_ready == 0, "R12", cpu_ready, 0);
    for (int k = 0; k <= gd; k++) begin
      @(negedge clk);
      bus_gnt = (k == gd);
      #1;
      chk(bus_req == 1, "R12", bus_req, 1);
      if (k < gd) begin
        chk(bus_cmd == 2'b00 && cpu_ready == 0, "R12", {bus_cmd, cpu_ready}, 0);
      end else begin
        chk(bus_cmd == (kind == 2 ? 2'b01 : (kind == 1 ? 2'b10 : 2'b11)), tg, bus_cmd,
            (kind == 2 ? 1 : (kind == 1 ? 2 : 3)));
        chk(bus_addr == 2'(idx) && bus_id == IW'(ME), tg, {bus_addr, bus_id}, {idx[1:0], 2'(ME)});
        chk(cpu_ready == (kind == 3), tg, cpu_ready, (kind == 3));
      end
    end
    @(negedge clk); bus_gnt = 0;
    if (kind != 3) begin
      #1;
      chk(cpu_ready == 0 && bus_req == 0, "R12", {cpu_ready, bus_req}, 0);
      @(negedge clk); bus_rsp_valid = 1; bus_rsp_data = rsp;
      #1;
      chk(cpu_ready == 1, tg, cpu_ready, 1);
      if (!wr) chk(cpu_rdata == rsp, tg, cpu_rdata, rsp);
      @(negedge clk); bus_rsp_valid = 0;
    end
    cpu_valid = 0;
    mst[idx]  = wr ? ST_M : ST_S;
    mdat[idx] = wr ? wd : rsp;
  endtask

  task automatic do_snoop(input logic [1:0] cmd, input int idx, input int id);
    bit eo, ew;
    string tg;
    eo = (id != ME) && mst[idx] == ST_M && (cmd == 2'b01 || cmd == 2'b10);
    ew = eo && cmd == 2'b01;
    if (id == ME)         tg = "R11";
    else if (cmd == 2'b01) tg = (mst[idx] == ST_M) ? "R8" : "R7";
    else if (cmd == 2'b10) tg = (mst[idx] == ST_M) ? "R9" : "R10";
    else                  tg = "R10";
    @(negedge clk);
    snp_cmd = cmd; snp_addr = 2'(idx); snp_id = IW'(id);
    #1;
    chk(snp_owned == eo && snp_wb == ew, tg, {snp_owned, snp_wb}, {eo, ew});
    if (eo) chk(snp_data == mdat[idx], tg, snp_data, mdat[idx]);
    @(negedge clk); snp_cmd = 2'b00;
    if (id != ME) begin
      if (cmd == 2'b01 && mst[idx] == ST_M) mst[idx] = ST_S;
      else if (cmd != 2'b01)                mst[idx] = ST_I;
    end
  endtask

  task automatic apply_op(input int op, input int idx);
    case (op)
      0: do_cpu(0, idx);
      1: do_cpu(1, idx);
      2: do_snoop(2'b01, idx, 2);
      3: do_snoop(2'b10, idx, 0);
      4: do_snoop(2'b11, idx, 3);
      5: do_snoop(2'b01, idx, ME);
      default: do_snoop(2'b10, idx, ME);
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_valid = 0; cpu_write = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; bus_rsp_valid = 0; bus_rsp_data = 0;
    snp_cmd = 0; snp_addr = 0; snp_id = 0;
    for (int i = 0; i < NL; i++) begin mst[i] = ST_I; mdat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset leaves every line Invalid
    chk(cpu_ready == 0 && bus_req == 0 && bus_cmd == 0, "R1", {cpu_ready, bus_req, bus_cmd}, 0);
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); snp_cmd = 2'b10; snp_addr = 2'(i); snp_id = 2; #1;
      chk(snp_owned == 0, "R1", snp_owned, 0);
    end
    @(negedge clk); snp_cmd = 0;
    do_cpu(0, 0);  // first access to a reset line misses (R1, R2)

    // near-exhaustive sweep: every ordered pair of operations on every line
    for (int idx = 0; idx < NL; idx++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 7; b++) begin
          do_snoop(2'b10, idx, 2);
          apply_op(a, idx);
          apply_op(b, idx);
          do_cpu(0, idx);
        end

    // R13: snoop on the same line defers a processor write hit
    do_snoop(2'b10, 3, 2);
    do_cpu(1, 3);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = 3; cpu_wdata = 8'h5C;
    snp_cmd = 2'b01; snp_addr = 3; snp_id = 2;
    #1;
    chk(cpu_ready == 0, "R13", cpu_ready, 0);
    chk(snp_owned == 1 && snp_wb == 1 && snp_data == mdat[3], "R13", snp_data, mdat[3]);
    @(negedge clk); snp_cmd = 0; cpu_valid = 0;
    mst[3] = ST_S;
    do_cpu(1, 3);  // now an upgrade (R8 downgrade seen through R4)

    // R13: pending upgrade overtaken by an invalidation becomes read-for-ownership
    do_snoop(2'b10, 2, 2);
    do_cpu(0, 2);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_addr = 2; cpu_wdata = 8'hE7;
    #1; chk(cpu_ready == 0, "R13", cpu_ready, 0);
    @(negedge clk); snp_cmd = 2'b11; snp_addr = 2; snp_id = 3;
    #1; chk(bus_req == 1 && bus_cmd == 0, "R13", {bus_req, bus_cmd}, 4);
    @(negedge clk); snp_cmd = 0; bus_gnt = 1;
    #1; chk(bus_cmd == 2'b10 && cpu_ready == 0, "R13", bus_cmd, 2);
    @(negedge clk); bus_gnt = 0;
    #1; chk(cpu_ready == 0, "R13", cpu_ready, 0);
    @(negedge clk); bus_rsp_valid = 1; bus_rsp_data = 8'h11;
    #1; chk(cpu_ready == 1, "R13", cpu_ready, 1);
    @(negedge clk); bus_rsp_valid = 0; cpu_valid = 0;
    mst[2] = ST_M; mdat[2] = 8'hE7;
    do_cpu(0, 2);
    do_snoop(2'b01, 2, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule